// File: doc/BRIEF.md
# Multidrop Serial Transceiver with Transmit Timeguard

This block is an asynchronous serial transceiver. Each frame carries eight data bits and a ninth, marker bit. When the block runs in multidrop mode, the marker bit tags each character as either an address (marker 1) or data (marker 0). This lets one master select among several receivers on a shared line. A send-address command tags the next character that is accepted as an address. On the receive side, a character arriving with its marker set raises an error-style flag. The flag stays set until a status-reset command clears it.

A programmable timeguard adds whole idle bit periods after the stop bit of every transmitted character, for receivers that need a pause between characters. The timeguard moves the point at which the holding register is released, which changes when the ready and empty flags report. A single oversample tick input sets the bit rate: one bit lasts 16 ticks for both directions.

Top module: `mdrop_uart`

## Requirements
- R1: A transmitted frame is: one low start bit, then eight data bits least significant first, then the marker bit, then one high stop bit. Each bit lasts 16 oversample ticks. The line rests high whenever no frame is in flight.
- R2: Multidrop mode is active only when the mode input equals 3'b110 or 3'b111. In any other mode, the transmitted marker is 0, the send-address command has no effect, and the marker flag is never set.
- R3: In multidrop mode, a character is sent with marker 0 unless a send-address command arrived before or together with the write that accepted it. In that case its marker is 1. The command applies to one accepted character only.
- R4: The receiver samples each bit at its midpoint and raises rx_rdy_o once it has sampled the stop bit, with the character on rx_data_o. A read strobe clears rx_rdy_o.
- R5: In multidrop mode, a received character whose marker bit is 1 sets pare_o. pare_o stays set through reads and later characters until a status-reset strobe clears it.
- R6: After the stop bit, the transmitter holds the line high for tg_i extra bit periods. tx_empty_o rises only after those periods have ended. With ticks on every cycle, tx_empty_o is seen high 177 + 16*tg_i cycles after the accepting write edge.
- R7: With tg_i = 0, tx_rdy_o returns high one cycle after the accepting write, when the character moves to the shifter. With tg_i nonzero, tx_rdy_o stays low until that character's start bit has been sent. This also holds for a character that waits behind another frame and its timeguard.
- R8: A write while tx_rdy_o is low is ignored. The character is never sent and does not replace the waiting one.
- R9: After reset, txd_o, tx_rdy_o and tx_empty_o are high, and rx_rdy_o and pare_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | Oversample tick, 16 per bit |
| par_mode_i | input | 3 | Ninth-bit mode; 3'b11x selects multidrop |
| tg_i | input | 8 | Timeguard length in bit periods |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| thr_data_i | input | 8 | Character to transmit |
| send_addr_i | input | 1 | Tag next accepted character as address |
| rst_sta_i | input | 1 | Status reset strobe, clears pare_o |
| rx_rd_i | input | 1 | Receive data read strobe |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| tx_rdy_o | output | 1 | Holding register free |
| tx_empty_o | output | 1 | Holding register and shifter idle, timeguard elapsed |
| rx_rdy_o | output | 1 | Received character available |
| rx_data_o | output | 8 | Last received character |
| pare_o | output | 1 | Received character carried marker 1 |

## Verification
The transmit line feeds the receive line, so each character goes through the whole path. A table of characters covers both multidrop mode codes and one non-multidrop code. Rows with and without a preceding send-address command separate marker insertion, its one-shot behaviour and its suppression outside multidrop. Timeguard values of 0, 1, 2 and 4 show that empty timing grows by exactly one bit period per count. Directed sequences queue a second character behind a guarded frame and interleave an extra write while the register is busy. These sequences separate the release rules for zero and nonzero timeguard and show that busy writes are dropped. A separate sequence checks that the marker flag survives reads and clears only on a status reset.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_MARK, TX_STOP, TX_GUARD
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_MARK, RX_STOP
  } rx_state_e;

  function automatic logic is_multidrop(input logic [2:0] mode);
    return mode[2:1] == 2'b11;
  endfunction
endpackage

// File: rtl/mdu_tx_hold.sv
module mdu_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              send_addr_i,
  input  logic              md_i,
  input  logic              release_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              addr_o
);
  logic              full_q, addr_q, pend_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept = wr_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      addr_q <= 1'b0;
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= data_i;
        addr_q <= md_i && (pend_q || send_addr_i);
        pend_q <= 1'b0;
      end else begin
        if (release_i) full_q <= 1'b0;
        if (send_addr_i && md_i) pend_q <= 1'b1;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/mdu_tx_engine.sv
module mdu_tx_engine
  import mdu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16,
  parameter int TG_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              full_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              addr_i,
  input  logic [TG_W-1:0]   tg_i,
  output logic              release_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int OS_W  = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W);

  tx_state_e         st_q;
  logic [OS_W-1:0]   os_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic [TG_W-1:0]   g_q;
  logic              mark_q, hold_q;
  logic              bit_end;

  assign bit_end = tick_i && (os_q == OS_W'(OS_RATE - 1));

  // guarded frames keep the holding register until the start bit is out
  assign release_o = (st_q == TX_IDLE && full_i && tg_i == '0) ||
                     (st_q == TX_START && bit_end && hold_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      os_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      g_q    <= '0;
      mark_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (st_q == TX_IDLE) begin
      if (full_i) begin
        st_q   <= TX_START;
        os_q   <= '0;
        sh_q   <= data_i;
        mark_q <= addr_i;
        hold_q <= (tg_i != '0);
      end
    end else if (tick_i) begin
      os_q <= bit_end ? '0 : os_q + 1'b1;
      if (bit_end) begin
        unique case (st_q)
          TX_START: begin
            st_q  <= TX_DATA;
            idx_q <= '0;
          end
          TX_DATA: begin
            sh_q <= sh_q >> 1;
            if (idx_q == IDX_W'(DATA_W - 1)) st_q <= TX_MARK;
            else idx_q <= idx_q + 1'b1;
          end
          TX_MARK: st_q <= TX_STOP;
          TX_STOP: begin
            if (tg_i != '0) begin
              st_q <= TX_GUARD;
              g_q  <= tg_i;
            end else begin
              st_q <= TX_IDLE;
            end
          end
          TX_GUARD: begin
            if (g_q == TG_W'(1)) st_q <= TX_IDLE;
            else g_q <= g_q - 1'b1;
          end
          default: st_q <= TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st_q)
      TX_START: txd_o = 1'b0;
      TX_DATA:  txd_o = sh_q[0];
      TX_MARK:  txd_o = mark_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign busy_o = (st_q != TX_IDLE);
endmodule

// File: rtl/mdu_rx_engine.sv
module mdu_rx_engine
  import mdu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mark_o
);
  localparam int OS_W  = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int HALF  = OS_RATE / 2;

  rx_state_e         st_q;
  logic [1:0]        sync_q;
  logic [OS_W-1:0]   os_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              mark_q, done_q;
  logic              rxs, full_bit;

  assign rxs      = sync_q[1];
  assign full_bit = (os_q == OS_W'(OS_RATE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      os_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      mark_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE: begin
            if (!rxs) begin
              st_q <= RX_START;
              os_q <= '0;
            end
          end
          RX_START: begin
            if (os_q == OS_W'(HALF - 1)) begin
              os_q  <= '0;
              idx_q <= '0;
              st_q  <= rxs ? RX_IDLE : RX_DATA;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          default: begin
            if (full_bit) begin
              os_q <= '0;
              unique case (st_q)
                RX_DATA: begin
                  sh_q <= {rxs, sh_q[DATA_W-1:1]};
                  if (idx_q == IDX_W'(DATA_W - 1)) st_q <= RX_MARK;
                  else idx_q <= idx_q + 1'b1;
                end
                RX_MARK: begin
                  mark_q <= rxs;
                  st_q   <= RX_STOP;
                end
                default: begin
                  done_q <= 1'b1;
                  st_q   <= RX_IDLE;
                end
              endcase
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q;
  assign mark_o = mark_q;
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
  import mdu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16,
  parameter int TG_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic [2:0]        par_mode_i,
  input  logic [TG_W-1:0]   tg_i,
  input  logic              thr_wr_i,
  input  logic [DATA_W-1:0] thr_data_i,
  input  logic              send_addr_i,
  input  logic              rst_sta_i,
  input  logic              rx_rd_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_empty_o,
  output logic              rx_rdy_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              pare_o
);
  logic              md;
  logic              hold_full, hold_addr, tx_release, tx_busy;
  logic [DATA_W-1:0] hold_data;
  logic              rx_done, rx_mark;
  logic [DATA_W-1:0] rx_char;
  logic              rx_rdy_q, pare_q;
  logic [DATA_W-1:0] rx_data_q;

  assign md = is_multidrop(par_mode_i);

  mdu_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (thr_wr_i),
    .data_i      (thr_data_i),
    .send_addr_i (send_addr_i),
    .md_i        (md),
    .release_i   (tx_release),
    .full_o      (hold_full),
    .data_o      (hold_data),
    .addr_o      (hold_addr)
  );

  mdu_tx_engine #(.DATA_W(DATA_W), .OS_RATE(OS_RATE), .TG_W(TG_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (os_tick_i),
    .full_i    (hold_full),
    .data_i    (hold_data),
    .addr_i    (hold_addr),
    .tg_i      (tg_i),
    .release_o (tx_release),
    .busy_o    (tx_busy),
    .txd_o     (txd_o)
  );

  mdu_rx_engine #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (os_tick_i),
    .rxd_i  (rxd_i),
    .done_o (rx_done),
    .data_o (rx_char),
    .mark_o (rx_mark)
  );

  // a new character wins over a same-cycle read or status reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_rdy_q  <= 1'b0;
      pare_q    <= 1'b0;
      rx_data_q <= '0;
    end else begin
      if (rx_done) begin
        rx_rdy_q  <= 1'b1;
        rx_data_q <= rx_char;
      end else if (rx_rd_i) begin
        rx_rdy_q <= 1'b0;
      end
      if (rx_done && rx_mark && md) pare_q <= 1'b1;
      else if (rst_sta_i)           pare_q <= 1'b0;
    end
  end

  assign tx_rdy_o   = !hold_full;
  assign tx_empty_o = !hold_full && !tx_busy;
  assign rx_rdy_o   = rx_rdy_q;
  assign rx_data_o  = rx_data_q;
  assign pare_o     = pare_q;
endmodule

// File: rtl/mdrop_uart_chk.sv
module mdrop_uart_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] par_mode_i,
  input logic       thr_wr_i,
  input logic       rst_sta_i,
  input logic       rx_rd_i,
  input logic       txd_o,
  input logic       tx_rdy_o,
  input logic       tx_empty_o,
  input logic       rx_rdy_o,
  input logic       pare_o
);
  a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o);

  a_r6_empty_needs_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_rdy_o);

  a_r7_rdy_falls_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_rdy_o) |-> $past(thr_wr_i));

  a_r4_rdy_clears_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_rdy_o) |-> $past(rx_rd_i));

  a_r5_pare_clears_on_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pare_o) |-> $past(rst_sta_i));

  a_r5_pare_with_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pare_o) |-> $rose(rx_rdy_o) || rx_rdy_o);

  a_r2_pare_only_multidrop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pare_o) |-> $past(par_mode_i[2:1]) == 2'b11);
endmodule

bind mdrop_uart mdrop_uart_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .par_mode_i (par_mode_i),
  .thr_wr_i   (thr_wr_i),
  .rst_sta_i  (rst_sta_i),
  .rx_rd_i    (rx_rd_i),
  .txd_o      (txd_o),
  .tx_rdy_o   (tx_rdy_o),
  .tx_empty_o (tx_empty_o),
  .rx_rdy_o   (rx_rdy_o),
  .pare_o     (pare_o)
);

// File: tb/mdrop_uart_tb_top.sv
module mdrop_uart_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       os_tick_i = 1'b1;
  logic [2:0] par_mode_i = 3'd6;
  logic [7:0] tg_i = 8'd0;
  logic       thr_wr_i = 1'b0;
  logic [7:0] thr_data_i = 8'd0;
  logic       send_addr_i = 1'b0;
  logic       rst_sta_i = 1'b0;
  logic       rx_rd_i = 1'b0;
  logic       txd_o, tx_rdy_o, tx_empty_o, rx_rdy_o, pare_o;
  logic [7:0] rx_data_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int wcyc = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  mdrop_uart dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .os_tick_i(os_tick_i),
    .par_mode_i(par_mode_i), .tg_i(tg_i), .thr_wr_i(thr_wr_i),
    .thr_data_i(thr_data_i), .send_addr_i(send_addr_i),
    .rst_sta_i(rst_sta_i), .rx_rd_i(rx_rd_i), .rxd_i(txd_o),
    .txd_o(txd_o), .tx_rdy_o(tx_rdy_o), .tx_empty_o(tx_empty_o),
    .rx_rdy_o(rx_rdy_o), .rx_data_o(rx_data_o), .pare_o(pare_o)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic       sa;
    logic [7:0] data;
    logic [7:0] tg;
    logic       mark;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{3'd6, 1'b0, 8'h5A, 8'd0, 1'b0},
    '{3'd6, 1'b1, 8'hA5, 8'd0, 1'b1},
    '{3'd7, 1'b1, 8'h01, 8'd4, 1'b1},
    '{3'd7, 1'b0, 8'hFF, 8'd1, 1'b0},
    '{3'd0, 1'b1, 8'h3C, 8'd2, 1'b0},
    '{3'd6, 1'b0, 8'h80, 8'd0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk_i);
    thr_data_i = d;
    thr_wr_i = 1'b1;
    @(negedge clk_i);
    thr_wr_i = 1'b0;
    wcyc = cyc;
  endtask

  task automatic pulse_sa();
    @(negedge clk_i); send_addr_i = 1'b1;
    @(negedge clk_i); send_addr_i = 1'b0;
  endtask

  task automatic pulse_sta();
    @(negedge clk_i); rst_sta_i = 1'b1;
    @(negedge clk_i); rst_sta_i = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk_i); rx_rd_i = 1'b1;
    @(negedge clk_i); rx_rd_i = 1'b0;
  endtask

  task automatic wait_rx(input string req);
    int k = 0;
    while (!rx_rdy_o && k < 2000) begin
      @(negedge clk_i);
      k++;
    end
    if (!rx_rdy_o) check(req, 0, 1);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 txd", txd_o, 1);
    check("R9 tx_rdy", tx_rdy_o, 1);
    check("R9 tx_empty", tx_empty_o, 1);
    check("R9 rx_rdy", rx_rdy_o, 0);
    check("R9 pare", pare_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      par_mode_i = VEC[i].mode;
      tg_i = VEC[i].tg;
      if (VEC[i].sa) pulse_sa();
      write(VEC[i].data);
      n = 0;
      while (!tx_empty_o && n < 3000) begin
        @(negedge clk_i);
        n = cyc - wcyc;
        if (n == 9)   check("R1 start bit", txd_o, 0);
        if (n == 25)  check("R1 first data bit lsb", txd_o, VEC[i].data[0]);
        if (n == 137) check("R1 last data bit", txd_o, VEC[i].data[7]);
        if (n == 153) check("R3 R2 marker bit", txd_o, VEC[i].mark);
        if (n == 169) check("R1 stop bit", txd_o, 1);
        if (VEC[i].tg != 0 && n == 185) check("R6 guard idle", txd_o, 1);
      end
      check("R6 empty timing", n, 177 + 16 * VEC[i].tg);
      wait_rx("R4 rx ready");
      check("R4 rx data", rx_data_o, VEC[i].data);
      check("R5 R2 pare", pare_o, VEC[i].mark);
      pulse_rd();
      check("R4 read clears", rx_rdy_o, 0);
      pulse_sta();
    end

    // R7 TG=0: ready returns one cycle after write
    par_mode_i = 3'd6;
    tg_i = 8'd0;
    write(8'h12);
    n = 0;
    while (!tx_rdy_o && n < 500) begin @(negedge clk_i); n = cyc - wcyc; end
    check("R7 rdy tg0", n, 1);
    while (!tx_empty_o) @(negedge clk_i);
    wait_rx("R4 rx");
    pulse_rd();

    // R7 TG=3: ready after start bit; second waiting char; R8 busy write dropped
    tg_i = 8'd3;
    write(8'hC3);
    begin
      int wa;
      wa = wcyc;
      n = 0;
      while (!tx_rdy_o && n < 500) begin @(negedge clk_i); n = cyc - wa; end
      check("R7 rdy tg3 first", n, 17);
      write(8'h4B);
      write(8'h77);  // R8: tx_rdy low, must be dropped
      n = cyc - wa;
      while (!tx_rdy_o && n < 1000) begin @(negedge clk_i); n = cyc - wa; end
      check("R7 rdy tg3 waiting char", n, 194 + 16 * 3);
    end
    check("R4 first char", rx_data_o, 8'hC3);
    pulse_rd();
    wait_rx("R4 rx second");
    check("R8 second char not overwritten", rx_data_o, 8'h4B);
    pulse_rd();
    while (!tx_empty_o) @(negedge clk_i);
    repeat (250) @(negedge clk_i);
    check("R8 no extra char", rx_rdy_o, 0);
    check("R8 line idle", txd_o, 1);

    // R5 persistence of pare
    tg_i = 8'd0;
    par_mode_i = 3'd7;
    pulse_sa();
    write(8'h11);
    wait_rx("R5 rx");
    check("R5 set", pare_o, 1);
    pulse_rd();
    check("R5 survives read", pare_o, 1);
    pulse_sa();
    write(8'h22);  // R3 second address char keeps flag
    while (!tx_empty_o) @(negedge clk_i);
    wait_rx("R5 rx2");
    pulse_rd();
    write(8'h33);  // data char must not clear it
    while (!tx_empty_o) @(negedge clk_i);
    wait_rx("R5 rx3");
    check("R5 survives data char", pare_o, 1);
    pulse_sta();
    check("R5 cleared by status reset", pare_o, 0);
    pulse_rd();

    finish_run();
  end
endmodule